// File: doc/BRIEF.md
# Multi-Channel Receive FIFO

A receive buffer whose storage is divided among a fixed number of logical channels. Each channel keeps its own write pointer, read pointer and occupancy count. The block has two synchronous ports on the same clock. On the producer port, an 8-bit channel number selects a channel, and 32-bit words are pushed into it. A push is either a single beat or a burst of fixed length that the FIFO ends by itself. This port sees the selected channel's fill state as discrete flags and as a count of free slots.

On the consumer port, an 8-bit channel number also selects a channel. A request on this port either fetches a packed status word or pops the oldest data word. Each request is answered with an acknowledge or an error acknowledge. On each port a ready output shows that the selected channel is active and that its status is stable. When the channel number changes, that port spends one cycle switching context before it serves requests again.

Top module: `mc_rx_fifo`

## Requirements
- R1: After reset every channel is empty. A status read of any channel returns 0xE0000000, the free-slot count equals DEPTH, and full, almost full and half full are all low.
- R2: A port's ready output is low in the first cycle in which a new channel number is presented, and it is high from the next cycle on. It is never high for a channel number of NCH or above. While ready is low, that port gives neither acknowledge nor error.
- R3: A status request on a ready consumer port is acknowledged in the same cycle. The status word is laid out as follows: bit 31 is set when occupancy is 0, bit 30 when occupancy is at most 1, bit 29 when occupancy is at most DEPTH/2, bits 7:0 hold the occupancy, and all other bits are zero.
- R4: A push request with burst low is acknowledged once, and the word is stored at the end of that cycle. No further acknowledge is given until the request has been seen low.
- R5: A push request with burst high is acknowledged on four consecutive cycles, storing four words. After that the acknowledge stays low while the request stays high. If the request drops before the fourth beat, the burst ends.
- R6: A push to a full channel gets an error acknowledge and stores nothing. The transfer then ends, and the port waits for the request to go low.
- R7: A data request on a ready consumer port with a non-empty channel is acknowledged. The channel's oldest word appears on the read bus in that same cycle and is removed at the end of the cycle. Words leave each channel in the order they were pushed.
- R8: A data request to an empty channel gets an error acknowledge, and the channel's state does not change.
- R9: The producer flags for the selected channel behave as follows: the free-slot count is DEPTH minus occupancy; full means occupancy equals DEPTH; almost full means at most one free slot; half full means occupancy is at least DEPTH/2.
- R10: Channels are independent: pushes and pops on one channel do not change what any other channel holds.
- R11: A push and a pop on the same channel in the same cycle both take effect, and fullness and emptiness are judged on the state before that cycle. When status and data are requested together, the status is returned and nothing is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_ch | input | 8 | Consumer channel number |
| rd_stat_req | input | 1 | Status read request |
| rd_data_req | input | 1 | Data pop request |
| rd_ack | output | 1 | Consumer acknowledge |
| rd_err | output | 1 | Consumer error acknowledge |
| rd_ch_valid | output | 1 | Consumer channel ready |
| rd_data | output | 32 | Status word or popped data |
| wr_ch | input | 8 | Producer channel number |
| wr_ch_valid | output | 1 | Producer channel ready |
| wr_burst | input | 1 | Burst qualifier, sampled when the request starts |
| wr_req | input | 1 | Push request |
| wr_ack | output | 1 | Push acknowledge |
| wr_err | output | 1 | Push error acknowledge |
| wr_data | input | 32 | Push data |
| wr_half_full | output | 1 | Selected channel at least half full |
| wr_almost_full | output | 1 | Selected channel has at most one free slot |
| wr_full | output | 1 | Selected channel full |
| wr_vacancy | output | 8 | Free slots in the selected channel |

## Verification
The critical overlap is a push and a pop landing on the same channel in the same cycle. This is worst when the channel is full or empty, because the error decision must use the state before the cycle while the occupancy must absorb both changes. The bench provokes this by pointing both ports at one channel, running bursts into it while the consumer pops, and by driving random traffic in which both ports frequently share a channel. Every cycle, a per-channel queue model predicts acknowledge, error, read data and flags, and these are compared with the outputs.

// File: rtl/mc_rx_fifo.sv
module mc_rx_fifo #(
  parameter int NCH   = 4,
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int CHW   = 8,
  parameter int BLEN  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CHW-1:0] rd_ch,
  input  logic           rd_stat_req,
  input  logic           rd_data_req,
  output logic           rd_ack,
  output logic           rd_err,
  output logic           rd_ch_valid,
  output logic [DW-1:0]  rd_data,
  input  logic [CHW-1:0] wr_ch,
  output logic           wr_ch_valid,
  input  logic           wr_burst,
  input  logic           wr_req,
  output logic           wr_ack,
  output logic           wr_err,
  input  logic [DW-1:0]  wr_data,
  output logic           wr_half_full,
  output logic           wr_almost_full,
  output logic           wr_full,
  output logic [7:0]     wr_vacancy
);
  localparam int CW = $clog2(NCH);
  localparam int PW = $clog2(DEPTH);
  localparam int OW = $clog2(DEPTH + 1);
  localparam int BW = $clog2(BLEN);

  typedef enum logic [1:0] {W_IDLE, W_BURST, W_WAIT} wst_t;

  logic [DW-1:0]  mem [NCH*DEPTH];
  logic [PW-1:0]  wp [NCH];
  logic [PW-1:0]  rp [NCH];
  logic [OW-1:0]  occ [NCH];
  logic [CHW-1:0] wch_q, rch_q;
  logic           live_q;
  wst_t           wst, wst_nxt;
  logic [BW-1:0]  bcnt, bcnt_nxt;

  logic [CW-1:0] wci, rci;
  logic [OW-1:0] w_occ, r_occ;
  logic          w_take, w_refuse, r_pop;

  assign wci = wch_q[CW-1:0];
  assign rci = rch_q[CW-1:0];
  assign w_occ = occ[wci];
  assign r_occ = occ[rci];

  assign wr_ch_valid = live_q && (wr_ch == wch_q) && (wr_ch < CHW'(NCH));
  assign rd_ch_valid = live_q && (rd_ch == rch_q) && (rd_ch < CHW'(NCH));

  assign wr_full        = (w_occ == OW'(DEPTH));
  assign wr_almost_full = (w_occ >= OW'(DEPTH - 1));
  assign wr_half_full   = (w_occ >= OW'(DEPTH / 2));
  assign wr_vacancy     = 8'(DEPTH) - 8'(w_occ);

  always_comb begin
    w_take   = 1'b0;
    w_refuse = 1'b0;
    wst_nxt  = wst;
    bcnt_nxt = bcnt;
    case (wst)
      W_IDLE:
        if (wr_ch_valid && wr_req) begin
          if (wr_full) begin
            w_refuse = 1'b1;
            wst_nxt  = W_WAIT;
          end else begin
            w_take = 1'b1;
            if (wr_burst) begin
              wst_nxt  = W_BURST;
              bcnt_nxt = BW'(1);
            end else begin
              wst_nxt = W_WAIT;
            end
          end
        end
      W_BURST:
        if (!(wr_ch_valid && wr_req)) begin
          wst_nxt = W_IDLE;
        end else if (wr_full) begin
          w_refuse = 1'b1;
          wst_nxt  = W_WAIT;
        end else begin
          w_take = 1'b1;
          if (bcnt == BW'(BLEN - 1)) wst_nxt = W_WAIT;
          else bcnt_nxt = bcnt + BW'(1);
        end
      default:
        if (!wr_req) wst_nxt = W_IDLE;
    endcase
  end

  assign wr_ack = w_take;
  assign wr_err = w_refuse;

  function automatic logic [DW-1:0] stat_word(input logic [OW-1:0] n);
    logic [DW-1:0] s;
    s = '0;
    s[DW-1] = (n == '0);
    s[DW-2] = (n <= OW'(1));
    s[DW-3] = (n <= OW'(DEPTH / 2));
    s[7:0]  = 8'(n);
    return s;
  endfunction

  assign r_pop  = rd_ch_valid && !rd_stat_req && rd_data_req && (r_occ != '0);
  assign rd_ack = (rd_ch_valid && rd_stat_req) || r_pop;
  assign rd_err = rd_ch_valid && !rd_stat_req && rd_data_req && (r_occ == '0);
  assign rd_data = (rd_ch_valid && rd_stat_req) ? stat_word(r_occ) :
                   r_pop ? mem[{rci, rp[rci]}] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wch_q  <= '0;
      rch_q  <= '0;
      live_q <= 1'b0;
      wst    <= W_IDLE;
      bcnt   <= '0;
    end else begin
      wch_q  <= wr_ch;
      rch_q  <= rd_ch;
      live_q <= 1'b1;
      wst    <= wst_nxt;
      bcnt   <= bcnt_nxt;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic push_c, pop_c;
    assign push_c = w_take && (wci == CW'(c));
    assign pop_c  = r_pop && (rci == CW'(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp[c]  <= '0;
        rp[c]  <= '0;
        occ[c] <= '0;
      end else begin
        if (push_c) wp[c] <= wp[c] + PW'(1);
        if (pop_c)  rp[c] <= rp[c] + PW'(1);
        if (push_c && !pop_c) occ[c] <= occ[c] + OW'(1);
        else if (pop_c && !push_c) occ[c] <= occ[c] - OW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (w_take) mem[{wci, wp[wci]}] <= wr_data;
  end

  a_r2_wr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ch_valid |-> !wr_ack && !wr_err);
  a_r2_rd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ch_valid |-> !rd_ack && !rd_err);
  a_r3_stat_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ch_valid && rd_stat_req) |-> rd_ack && !rd_err);
  a_r4_single_once: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && wst == W_IDLE && !wr_burst) |=> !wr_ack);
  a_r5_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && $past(wr_ack) && $past(wr_ack, 2) && $past(wr_ack, 3)) |=> !wr_ack);
  a_r6_full_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ch_valid && wr_full) |-> !wr_ack);
  a_r8_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> !rd_ack && !rd_stat_req);
  a_r9_full_flags: assert property (@(posedge clk) disable iff (!rst_n)
    wr_full |-> wr_almost_full && wr_half_full && wr_vacancy == 8'd0);
endmodule

// File: tb/tb_mc_rx_fifo.sv
module tb_mc_rx_fifo;
  localparam int CLK_P = 10;
  localparam int NCH = 4, DEPTH = 8;

  logic clk = 0, rst_n = 0;
  logic [7:0] rd_ch = 0, wr_ch = 0;
  logic rd_stat_req = 0, rd_data_req = 0, wr_burst = 0, wr_req = 0;
  logic [31:0] wr_data = 0;
  logic rd_ack, rd_err, rd_ch_valid, wr_ch_valid, wr_ack, wr_err;
  logic wr_half_full, wr_almost_full, wr_full;
  logic [31:0] rd_data;
  logic [7:0] wr_vacancy;

  mc_rx_fifo dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] q [NCH][$];
  logic [7:0] wq = 0, rq = 0;
  bit live = 0;
  int wst = 0, bcnt = 0;

  function automatic logic [31:0] stat_exp(int n);
    logic [31:0] s = '0;
    s[31] = (n == 0); s[30] = (n <= 1); s[29] = (n <= DEPTH/2);
    s[7:0] = 8'(n);
    return s;
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    bit ev_w, ev_r, full, take, refuse, sp, dp, pop;
    int n;
    int wc = int'(wr_ch), rc = int'(rd_ch);
    #1;
    ev_w = live && wr_ch == wq && wr_ch < NCH;
    ev_r = live && rd_ch == rq && rd_ch < NCH;
    chk(wr_ch_valid, ev_w, "R2 wr valid");
    chk(rd_ch_valid, ev_r, "R2 rd valid");
    full = ev_w && q[wc].size() == DEPTH;
    take = 0; refuse = 0;
    if (wst == 0) begin
      if (ev_w && wr_req) begin
        if (full) refuse = 1; else take = 1;
      end
    end else if (wst == 1) begin
      if (ev_w && wr_req) begin
        if (full) refuse = 1; else take = 1;
      end
    end
    chk(wr_ack, take, wst == 1 ? "R5 burst ack" : "R4 push ack");
    chk(wr_err, refuse, "R6 push err");
    if (ev_w) begin
      n = q[wc].size();
      chk(wr_vacancy, DEPTH - n, "R9 vacancy");
      chk(wr_full, n == DEPTH, "R9 full");
      chk(wr_almost_full, DEPTH - n <= 1, "R9 almost full");
      chk(wr_half_full, n >= DEPTH/2, "R9 half full");
    end
    sp = ev_r && rd_stat_req;
    dp = ev_r && !rd_stat_req && rd_data_req;
    pop = dp && q[rc].size() != 0;
    chk(rd_ack, sp || pop, "R7 rd ack");
    chk(rd_err, dp && q[rc].size() == 0, "R8 empty err");
    if (sp) chk(rd_data, stat_exp(q[rc].size()), "R3 status word");
    else if (pop) chk(rd_data, q[rc][0], "R7 fifo order");
    @(posedge clk);
    if (pop) void'(q[rc].pop_front());
    if (take) q[wc].push_back(wr_data);
    if (wst == 0) begin
      if (ev_w && wr_req) begin
        if (refuse || !wr_burst) wst = 2; else begin wst = 1; bcnt = 1; end
      end
    end else if (wst == 1) begin
      if (!(ev_w && wr_req)) wst = 0;
      else if (refuse) wst = 2;
      else if (bcnt == 3) wst = 2;
      else bcnt++;
    end else if (!wr_req) wst = 0;
    wq = wr_ch; rq = rd_ch; live = 1;
    @(negedge clk);
    wr_data = $urandom;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc();
    // R1: every channel empty after reset
    for (int c = 0; c < NCH; c++) begin
      rd_ch = 8'(c); wr_ch = 8'(c); rd_stat_req = 1;
      cyc();
      #1;
      chk(rd_data, 32'hE000_0000, "R1 reset status");
      chk(wr_vacancy, DEPTH, "R1 reset vacancy");
      chk({wr_full, wr_almost_full, wr_half_full}, 0, "R1 reset flags");
      cyc();
    end
    rd_stat_req = 0; wr_ch = 0; rd_ch = 0; cyc();
    // R4: single beat with held request
    wr_req = 1; wr_burst = 0; repeat (4) cyc();
    wr_req = 0; cyc();
    // R5: burst with held request, then early drop
    wr_req = 1; wr_burst = 1; repeat (7) cyc();
    wr_req = 0; cyc();
    wr_req = 1; repeat (2) cyc(); wr_req = 0; cyc();
    // R6, R9: overfill channel 1
    wr_ch = 1; cyc();
    for (int k = 0; k < 4; k++) begin
      wr_req = 1; wr_burst = 1; repeat (5) cyc();
      wr_req = 0; cyc();
    end
    // R7, R8, R10: drain channel 1 past empty, channel 0 untouched
    rd_ch = 1; rd_data_req = 1; repeat (12) cyc();
    // R11: status priority over data
    rd_ch = 0; rd_stat_req = 1; repeat (3) cyc();
    rd_stat_req = 0; repeat (2) cyc();
    // R11: push and pop on one channel together, also at full
    wr_ch = 2; rd_ch = 2; rd_data_req = 0;
    for (int k = 0; k < 3; k++) begin
      wr_req = 1; wr_burst = 1; repeat (4) cyc(); wr_req = 0; cyc();
    end
    rd_data_req = 1; wr_req = 1; wr_burst = 1; repeat (5) cyc();
    wr_req = 0; repeat (10) cyc(); rd_data_req = 0;
    // R2: out-of-range channel never ready
    wr_ch = NCH; rd_ch = 8'hFF; wr_req = 1; rd_stat_req = 1; repeat (3) cyc();
    wr_req = 0; rd_stat_req = 0; wr_ch = 0; rd_ch = 0; cyc();
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(9) == 0) wr_ch = ($urandom_range(19) == 0) ? 8'(NCH) : 8'($urandom_range(NCH-1));
      if ($urandom_range(9) == 0) rd_ch = 8'($urandom_range(NCH-1));
      if ($urandom_range(3) == 0) rd_ch = wr_ch;
      wr_req = $urandom_range(99) < 60;
      wr_burst = $urandom_range(2) == 0;
      rd_stat_req = $urandom_range(9) == 0;
      rd_data_req = $urandom_range(99) < 45;
      cyc();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule